// File: doc/BRIEF.md
# Strided Prefetch Burst Generator

This block turns one prefetch trigger into a short run of prefetch addresses. A trigger carries a base address and a signed stride that some earlier stage has already detected. The block first widens the stride so that each step moves at least one cache line, and it keeps the stride's sign. It then jumps ahead of the demand stream by a configured number of strides and emits a configured number of line addresses, one per handshake, on a valid/ready stream. The final address of each burst is flagged. Every value is formed with adders and shifts, so no multiplier is used.

Control is a three-state machine. `ST_IDLE` accepts a trigger. `ST_OFFSET` forms the skip offset one distance bit per cycle by shift-and-add. `ST_EMIT` presents addresses. The transitions are:
- IDLE→IDLE when no trigger is presented, or when the trigger carries a zero stride or a zero degree (the trigger is taken and dropped).
- IDLE→OFFSET when a trigger is accepted.
- OFFSET→OFFSET while distance bits remain.
- OFFSET→EMIT when the distance bits are used up, with one stride added in the same cycle.
- EMIT→EMIT while addresses remain or the consumer stalls.
- EMIT→IDLE on the handshake of the last address.

The degree, the distance and the line-size shift are sampled when a trigger is accepted and are held for the whole burst.

Top module: `stride_burst_gen`

## Requirements
- R1: `trig_ready` is 1 only in the idle state. It stays 0 from the cycle after a trigger is accepted until the last address of that burst has been handshaken, and it is never 1 while `pf_valid` is 1.
- R2: The line size is 1 << `cfg_line_shift`. If the absolute value of `trig_stride` is smaller than the line size, the effective stride is +line size for a positive stride and −line size for a negative stride. Otherwise the effective stride is `trig_stride`, sign-extended.
- R3: The k-th address of a burst (k = 1..degree) equals `trig_base` + (`cfg_distance` + k) × effective stride, modulo 2^ADDR_W.
- R4: A burst with nonzero stride and nonzero degree delivers exactly `cfg_degree` addresses. `pf_last` is 1 on the final address only. In the cycle after that final handshake, `pf_valid` is 0 and `trig_ready` is 1.
- R5: A trigger with `trig_stride` = 0 is consumed without producing any address. `trig_ready` is 1 again in the next cycle.
- R6: A trigger with `cfg_degree` = 0 is consumed without producing any address. `trig_ready` is 1 again in the next cycle.
- R7: While `pf_valid` is 1 and `pf_ready` is 0, `pf_valid`, `pf_addr` and `pf_last` hold their values into the next cycle.
- R8: Changes to the trigger fields or to the configuration inputs after a trigger has been accepted have no effect on the burst that is running.
- R9: After reset, `trig_ready` is 1 and `pf_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_valid | input | 1 | Trigger offered |
| trig_ready | output | 1 | Trigger accepted this cycle when high with trig_valid |
| trig_base | input | ADDR_W | Base address of the trigger |
| trig_stride | input | STRIDE_W | Signed detected stride, two's complement |
| cfg_degree | input | DEG_W | Number of addresses per burst |
| cfg_distance | input | DIST_W | Strides to skip before the first address |
| cfg_line_shift | input | LINE_W | log2 of the cache line size in bytes |
| pf_valid | output | 1 | Prefetch address valid |
| pf_ready | input | 1 | Consumer takes the address |
| pf_addr | output | ADDR_W | Prefetch address |
| pf_last | output | 1 | Final address of the burst |

## Verification
Bursts are tried with both small and large strides of each sign, and each line size is used with strides on both sides of it. This shows whether the rounding to a full line keeps the sign and leaves large strides untouched. Distances of zero, of a single set bit and of several set bits check each step of the shift-and-add offset. A base address near the top of the range checks the wraparound. Zero stride and zero degree are sent as directed cases. Random backpressure on `pf_ready` covers the holding of the output. On some triggers the inputs are changed straight after acceptance, which shows whether the burst reads its latched copy of the fields or the live inputs.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OFFSET = 2'd1,
        ST_EMIT   = 2'd2
    } sbg_state_e;
endpackage

// File: rtl/sbg_stride_norm.sv
// Widens a detected stride to at least one cache line, preserving sign.
module sbg_stride_norm #(
    parameter int ADDR_W   = 48,
    parameter int STRIDE_W = 24,
    parameter int LINE_W   = 4
) (
    input  logic signed [STRIDE_W-1:0] stride_i,
    input  logic        [LINE_W-1:0]   line_shift_i,
    output logic        [ADDR_W-1:0]   eff_o,
    output logic                       zero_o
);
    localparam int EXT_W = ADDR_W - STRIDE_W - 1;
    localparam int SX_W  = ADDR_W - STRIDE_W;

    logic                neg;
    logic [STRIDE_W:0]   wide;
    logic [STRIDE_W:0]   mag;
    logic [ADDR_W-1:0]   mag_ext;
    logic [ADDR_W-1:0]   line;
    logic [ADDR_W-1:0]   stride_sx;
    logic [ADDR_W-1:0]   eff_mag;

    always_comb begin
        neg       = stride_i[STRIDE_W-1];
        wide      = {stride_i[STRIDE_W-1], stride_i};
        mag       = neg ? (~wide + 1'b1) : wide;
        mag_ext   = {{EXT_W{1'b0}}, mag};
        line      = {{(ADDR_W-1){1'b0}}, 1'b1} << line_shift_i;
        stride_sx = {{SX_W{stride_i[STRIDE_W-1]}}, stride_i};
        zero_o    = (stride_i == '0);
        if (mag_ext < line) begin
            eff_o = neg ? (~line + 1'b1) : line;
        end else begin
            eff_o = stride_sx;
        end
        eff_mag = eff_o[ADDR_W-1] ? (~eff_o + 1'b1) : eff_o;
    end

    always_comb begin
        if (!zero_o) begin
            AST_SIGN_KEPT: assert (eff_o[ADDR_W-1] == neg);  // R2
            AST_AT_LEAST_LINE: assert (eff_mag >= line);     // R2
        end
    end
endmodule

// File: rtl/sbg_addr_path.sv
// Running-address datapath: shift-and-add offset, then repeated stride add.
module sbg_addr_path #(
    parameter int ADDR_W = 48,
    parameter int DIST_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic [DIST_W-1:0] dist_i,
    input  logic              off_step_i,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] run_o,
    output logic [ADDR_W-1:0] stride_o,
    output logic              dist_done_o
);
    logic [ADDR_W-1:0] run_q;
    logic [ADDR_W-1:0] stride_q;
    logic [ADDR_W-1:0] step_q;
    logic [DIST_W-1:0] dist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q    <= '0;
            stride_q <= '0;
            step_q   <= '0;
            dist_q   <= '0;
        end else if (load_i) begin
            run_q    <= base_i;
            stride_q <= stride_i;
            step_q   <= stride_i;
            dist_q   <= dist_i;
        end else if (off_step_i) begin
            if (dist_q[0]) begin
                run_q <= run_q + step_q;
            end
            step_q <= step_q << 1;
            dist_q <= dist_q >> 1;
        end else if (adv_i) begin
            run_q <= run_q + stride_q;
        end
    end

    assign run_o       = run_q;
    assign stride_o    = stride_q;
    assign dist_done_o = (dist_q == '0);

    AST_OFFSET_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        off_step_i && !load_i |=> dist_q < $past(dist_q));  // R3
endmodule

// File: rtl/stride_burst_gen.sv
module stride_burst_gen
    import sbg_pkg::*;
#(
    parameter int ADDR_W   = 48,
    parameter int STRIDE_W = 24,
    parameter int DEG_W    = 4,
    parameter int DIST_W   = 6,
    parameter int LINE_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       trig_valid,
    output logic                       trig_ready,
    input  logic        [ADDR_W-1:0]   trig_base,
    input  logic signed [STRIDE_W-1:0] trig_stride,
    input  logic        [DEG_W-1:0]    cfg_degree,
    input  logic        [DIST_W-1:0]   cfg_distance,
    input  logic        [LINE_W-1:0]   cfg_line_shift,
    output logic                       pf_valid,
    input  logic                       pf_ready,
    output logic        [ADDR_W-1:0]   pf_addr,
    output logic                       pf_last
);
    localparam logic [DEG_W-1:0] ONE_LEFT = {{(DEG_W-1){1'b0}}, 1'b1};

    sbg_state_e        state_q, state_d;
    logic [DEG_W-1:0]  remain_q;
    logic [ADDR_W-1:0] eff_stride;
    logic              stride_zero;
    logic              accept, empty_trig;
    logic              load, off_step, adv;
    logic [ADDR_W-1:0] run_addr, held_stride;
    logic              dist_done;

    sbg_stride_norm #(
        .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .LINE_W(LINE_W)
    ) u_norm (
        .stride_i     (trig_stride),
        .line_shift_i (cfg_line_shift),
        .eff_o        (eff_stride),
        .zero_o       (stride_zero)
    );

    sbg_addr_path #(
        .ADDR_W(ADDR_W), .DIST_W(DIST_W)
    ) u_path (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .base_i      (trig_base),
        .stride_i    (eff_stride),
        .dist_i      (cfg_distance),
        .off_step_i  (off_step),
        .adv_i       (adv),
        .run_o       (run_addr),
        .stride_o    (held_stride),
        .dist_done_o (dist_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Remaining-address counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= cfg_degree;
        end else if (state_q == ST_EMIT && pf_ready && !pf_last) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // Outputs and datapath controls
    always_comb begin
        trig_ready = 1'b0;
        pf_valid   = 1'b0;
        pf_last    = 1'b0;
        load       = 1'b0;
        off_step   = 1'b0;
        adv        = 1'b0;
        accept     = 1'b0;
        empty_trig = stride_zero || (cfg_degree == '0);
        unique case (state_q)
            ST_IDLE: begin
                trig_ready = 1'b1;
                accept     = trig_valid;
                load       = trig_valid && !empty_trig;
            end
            ST_OFFSET: begin
                off_step = !dist_done;
                adv      = dist_done;
            end
            ST_EMIT: begin
                pf_valid = 1'b1;
                pf_last  = (remain_q == ONE_LEFT);
                adv      = pf_ready && !pf_last;
            end
            default: begin
                trig_ready = 1'b0;
            end
        endcase
    end

    assign pf_addr = run_addr;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && !empty_trig) state_d = ST_OFFSET;
            end
            ST_OFFSET: begin
                if (dist_done) state_d = ST_EMIT;
            end
            ST_EMIT: begin
                if (pf_ready && pf_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> !trig_ready);  // R1
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid && trig_ready && !empty_trig |=> !trig_ready);  // R1
    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr) && $stable(pf_last));  // R7
    AST_STRIDE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && pf_ready && !pf_last |=> pf_valid && (pf_addr == $past(pf_addr) + held_stride));  // R3
    AST_LAST_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && pf_ready && pf_last |=> trig_ready && !pf_valid);  // R4
    AST_EMPTY_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid && trig_ready && empty_trig |=> trig_ready && !pf_valid);  // R5, R6
    AST_REMAIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> remain_q != '0);  // R4
endmodule

// File: tb/tb_stride_burst_gen.sv
`timescale 1ns/1ps
module tb_stride_burst_gen;
    localparam int AW = 48;
    localparam int SW = 24;
    localparam int GW = 4;
    localparam int TW = 6;
    localparam int LW = 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 trig_valid = 1'b0;
    logic                 trig_ready;
    logic [AW-1:0]        trig_base = '0;
    logic signed [SW-1:0] trig_stride = '0;
    logic [GW-1:0]        cfg_degree = '0;
    logic [TW-1:0]        cfg_distance = '0;
    logic [LW-1:0]        cfg_line_shift = '0;
    logic                 pf_valid;
    logic                 pf_ready = 1'b0;
    logic [AW-1:0]        pf_addr;
    logic                 pf_last;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    stride_burst_gen dut (
        .clk(clk), .rst_n(rst_n),
        .trig_valid(trig_valid), .trig_ready(trig_ready),
        .trig_base(trig_base), .trig_stride(trig_stride),
        .cfg_degree(cfg_degree), .cfg_distance(cfg_distance),
        .cfg_line_shift(cfg_line_shift),
        .pf_valid(pf_valid), .pf_ready(pf_ready),
        .pf_addr(pf_addr), .pf_last(pf_last)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference: base + (distance + k) * effective stride, R2 and R3
    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic signed [SW-1:0] s,
                                               logic [LW-1:0] lsh, logic [TW-1:0] d, int k);
        longint line, sv, mag, eff, r;
        line = longint'(1) << lsh;
        sv   = longint'(s);
        mag  = (sv < 0) ? -sv : sv;
        eff  = (mag < line) ? ((sv < 0) ? -line : line) : sv;
        r    = longint'({16'b0, b}) + longint'(int'(d) + k) * eff;
        return r[AW-1:0];
    endfunction

    task automatic run_burst(input logic [AW-1:0] b, input logic signed [SW-1:0] s,
                             input logic [GW-1:0] g, input logic [TW-1:0] d,
                             input logic [LW-1:0] lsh, input bit scramble);
        int got;
        int guard;
        bit hold;
        logic [AW-1:0] held;
        @(negedge clk);
        while (!trig_ready) @(negedge clk);
        trig_valid = 1'b1; trig_base = b; trig_stride = s;
        cfg_degree = g; cfg_distance = d; cfg_line_shift = lsh;
        @(negedge clk);
        trig_valid = 1'b0;
        if (scramble) begin
            // R8: inputs change after acceptance
            trig_base = {$urandom, $urandom};
            trig_stride = SW'($urandom);
            cfg_degree = GW'($urandom);
            cfg_distance = TW'($urandom);
            cfg_line_shift = LW'($urandom);
        end
        if (s == 0 || g == 0) begin
            chk(trig_ready && !pf_valid, (s == 0) ? "R5 zero stride consumed" : "R6 zero degree consumed",
                {62'b0, trig_ready, pf_valid}, 64'h2);
            return;
        end
        chk(!trig_ready, "R1 busy after accept", 64'(trig_ready), 64'h0);
        got = 0; guard = 0; hold = 1'b0; held = '0;
        while (got < int'(g) && guard < 2000) begin
            if (hold) begin
                chk(pf_valid && pf_addr == held, "R7 output held under stall", 64'(pf_addr), 64'(held));
                hold = 1'b0;
            end
            if (pf_valid) chk(!trig_ready, "R1 ready low during burst", 64'(trig_ready), 64'h0);
            pf_ready = ($urandom % 4) != 0;
            if (pf_valid) begin
                if (pf_ready) begin
                    got++;
                    chk(pf_addr == exp_addr(b, s, lsh, d, got), scramble ? "R3 R8 address" : "R3 address",
                        64'(pf_addr), 64'(exp_addr(b, s, lsh, d, got)));
                    chk(pf_last == (got == int'(g)), "R4 last flag", 64'(pf_last), 64'(got == int'(g)));
                end else begin
                    hold = 1'b1;
                    held = pf_addr;
                end
            end
            @(negedge clk);
            guard++;
        end
        pf_ready = 1'b0;
        chk(got == int'(g), "R4 address count", 64'(got), 64'(g));
        chk(!pf_valid && trig_ready, "R4 idle after last", {62'b0, pf_valid, trig_ready}, 64'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk(trig_ready && !pf_valid, "R9 reset state", {62'b0, trig_ready, pf_valid}, 64'h2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(trig_ready && !pf_valid, "R9 after reset release", {62'b0, trig_ready, pf_valid}, 64'h2);

        // Directed corner cases
        run_burst(48'h0000_1000_0000, 24'sd0,    4'd4, 6'd0,  4'd6, 1'b0);  // R5
        run_burst(48'h0000_1000_0000, 24'sd8,    4'd0, 6'd3,  4'd6, 1'b0);  // R6
        run_burst(48'h0000_1000_0000, 24'sd8,    4'd4, 6'd0,  4'd6, 1'b0);  // R2 small positive
        run_burst(48'h0000_1000_0000, -24'sd8,   4'd4, 6'd1,  4'd6, 1'b0);  // R2 small negative
        run_burst(48'h0000_2000_0000, 24'sd200,  4'd3, 6'd5,  4'd6, 1'b0);  // R2 large kept
        run_burst(48'h0000_2000_0000, -24'sd200, 4'd3, 6'd6,  4'd6, 1'b0);  // R2 large negative
        run_burst(48'h0000_2000_0000, 24'sd64,   4'd2, 6'd2,  4'd6, 1'b0);  // R2 exactly one line
        run_burst(48'hFFFF_FFFF_FF00, 24'sd4096, 4'd15, 6'd63, 4'd6, 1'b0); // R3 wrap, max distance
        run_burst(48'h0000_0000_0100, -24'sd8388608, 4'd5, 6'd2, 4'd15, 1'b0); // R3 most negative
        run_burst(48'h0000_3000_0000, 24'sd1,    4'd1, 6'd0,  4'd0, 1'b0);  // R4 single address
        run_burst(48'h0000_4000_0000, 24'sd100,  4'd6, 6'd9,  4'd7, 1'b1);  // R8 scramble

        // Constrained random bursts
        for (int i = 0; i < 60; i++) begin
            logic signed [SW-1:0] s;
            if ($urandom % 2 == 0) s = SW'($signed($urandom % 129) - 64);
            else                   s = SW'($urandom);
            run_burst({$urandom, $urandom}, s, GW'($urandom % 9), TW'($urandom % 21),
                      LW'(2 + $urandom % 7), ($urandom % 3) == 0);
        end

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule